// File: doc/BRIEF.md
# Standby Power-Down Ramp Controller

This block sequences the power state of a speech output path so that the output never jumps. From reset it sits in standby with the 9-bit unsigned DAC code held at zero. A release request wakes it. The request is chip-select low together with the start strobe low, or, when the slave-mode input is set, chip-select low together with the write strobe low. After a short busy delay it raises the code one step at a time up to mid-scale, which is 0x100. It then waits a settling interval and issues a one-cycle start pulse to the synthesis datapath.

While synthesis runs, the DAC code follows the decoder sample. When the datapath reports completion, the code returns to mid-scale and a long idle hold begins. A new release request during the hold restarts synthesis at once, with no ramp. If the hold expires, the code walks down one step at a time to zero and the block re-enters standby.

All timing counts advance only on a clock-enable tick, which is meant to run at 640 kHz. Every interval is a parameter, so a test can shorten them.

Top module: `standby_ramp_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, standby_o=1, dac_o=0, busy_no=1 and synth_start_o=0.
- R2: In standby, dac_o is 0. A strobe applied while cs_ni is high does not leave standby.
- R3: Standby is left only on the clock edge where cs_ni=0 and the mode-selected strobe is 0. That strobe is start_ni when slave_mode_i=0 and wr_ni when slave_mode_i=1. The other strobe has no effect.
- R4: busy_no goes low exactly BUSY_TICKS ticks after the clock edge that captures the release request.
- R5: During the opening ramp, dac_o rises by exactly 1 every STEP_TICKS ticks, from 0 to 0x100, and never decreases.
- R6: SETTLE_TICKS ticks after dac_o reaches 0x100, synth_start_o pulses high for exactly one cycle.
- R7: From the start pulse until completion, busy_no=0 and dac_o equals sample_i delayed by one clock.
- R8: One clock after synth_done_i, dac_o=0x100 and busy_no=1. The block stays out of standby while it holds.
- R9: A release request during the hold produces synth_start_o on the next clock, with no ramp. dac_o is still 0x100 in that cycle.
- R10: After HOLD_TICKS ticks of hold, dac_o falls by 1 every STEP_TICKS ticks down to 0. standby_o rises in the same cycle that dac_o reaches 0.
- R11: All interval counters advance only in cycles with tick_i=1. With tick_i=0 the block stays in its current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing enable, nominally 640 kHz |
| cs_ni | input | 1 | Chip select, active low |
| start_ni | input | 1 | Start strobe, active low (stand-alone mode) |
| wr_ni | input | 1 | Write strobe, active low (slave mode) |
| slave_mode_i | input | 1 | Selects which strobe releases standby |
| synth_done_i | input | 1 | Synthesis datapath has finished |
| sample_i | input | 9 | Decoder sample for the DAC |
| dac_o | output | 9 | Unsigned DAC code |
| busy_no | output | 1 | Busy flag, active low |
| standby_o | output | 1 | High while in standby |
| synth_start_o | output | 1 | One-cycle pulse that starts synthesis |

## Verification
The embedded assertions check, on every cycle, the properties that hold cycle by cycle:
- dac_o is zero whenever the block is in standby.
- A wake happens only with chip-select low.
- Each ramp step moves the code by at most one, with no wrap.
- The code sits at mid-scale throughout the hold.
- The start pulse lasts one cycle.
- The interval counter stays below its limit and is frozen without a tick.

Only the bench scenarios can show exact cycle positions: the busy fall, the step positions, the start-pulse delay, and the end of the closing ramp. The same applies to the mode-dependent choice of strobe and to the restart from the hold without a ramp.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    ST_STANDBY,
    ST_WAKE,
    ST_RAMP_UP,
    ST_SETTLE,
    ST_SYNTH,
    ST_HOLD,
    ST_RAMP_DN
  } pwr_state_e;
endpackage

// File: rtl/sbr_wake_decode.sv
module sbr_wake_decode (
  input  logic cs_ni,
  input  logic start_ni,
  input  logic wr_ni,
  input  logic slave_i,
  output logic req_o
);
  logic strobe_n;
  assign strobe_n = slave_i ? wr_ni : start_ni;
  assign req_o    = !cs_ni && !strobe_n;
endmodule

// File: rtl/sbr_interval_timer.sv
module sbr_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_cnt_below_limit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);
  assert_frozen_without_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sbr_dac_ramp.sv
module sbr_dac_ramp #(
  parameter int DAC_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic             load_mid_i,
  input  logic             load_smp_i,
  input  logic [DAC_W-1:0] smp_i,
  output logic [DAC_W-1:0] code_o
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

  logic [DAC_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         code_q <= '0;
    else if (load_smp_i) code_q <= smp_i;
    else if (load_mid_i) code_q <= MID;
    else if (step_up_i)  code_q <= code_q + DAC_W'(1);
    else if (step_dn_i)  code_q <= code_q - DAC_W'(1);
  end

  assign code_o = code_q;

  assert_no_wrap_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_up_i |-> code_q < MID);
  assert_no_wrap_dn_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_dn_i |-> code_q != '0);
endmodule

// File: rtl/standby_ramp_ctrl.sv
module standby_ramp_ctrl
  import sbr_pkg::*;
#(
  parameter int DAC_W        = 9,
  parameter int BUSY_TICKS   = 5,
  parameter int STEP_TICKS   = 117,
  parameter int SETTLE_TICKS = 1408,
  parameter int HOLD_TICKS   = 1920000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cs_ni,
  input  logic             start_ni,
  input  logic             wr_ni,
  input  logic             slave_mode_i,
  input  logic             synth_done_i,
  input  logic [DAC_W-1:0] sample_i,
  output logic [DAC_W-1:0] dac_o,
  output logic             busy_no,
  output logic             standby_o,
  output logic             synth_start_o
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);
  localparam int MAX_A = (BUSY_TICKS > STEP_TICKS) ? BUSY_TICKS : STEP_TICKS;
  localparam int MAX_B = (SETTLE_TICKS > HOLD_TICKS) ? SETTLE_TICKS : HOLD_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);

  pwr_state_e       state_q, state_d;
  logic             req, tmr_done, start_q, start_d;
  logic             step_up, step_dn, load_mid, load_smp;
  logic [CNT_W-1:0] limit;

  sbr_wake_decode i_wake (
    .cs_ni    (cs_ni),
    .start_ni (start_ni),
    .wr_ni    (wr_ni),
    .slave_i  (slave_mode_i),
    .req_o    (req)
  );

  always_comb begin
    case (state_q)
      ST_WAKE:                limit = CNT_W'(BUSY_TICKS);
      ST_RAMP_UP, ST_RAMP_DN: limit = CNT_W'(STEP_TICKS);
      ST_SETTLE:              limit = CNT_W'(SETTLE_TICKS);
      ST_HOLD:                limit = CNT_W'(HOLD_TICKS);
      default:                limit = CNT_W'(1);
    endcase
  end

  sbr_interval_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_d != state_q),
    .en_i    (tick_i),
    .limit_i (limit),
    .done_o  (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    start_d  = 1'b0;
    step_up  = 1'b0;
    step_dn  = 1'b0;
    load_mid = 1'b0;
    load_smp = 1'b0;
    case (state_q)
      ST_STANDBY: if (req) state_d = ST_WAKE;
      ST_WAKE:    if (tmr_done) state_d = ST_RAMP_UP;
      ST_RAMP_UP: if (tmr_done) begin
        step_up = 1'b1;
        if (dac_o == MID - DAC_W'(1)) state_d = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_done) begin
        start_d = 1'b1;
        state_d = ST_SYNTH;
      end
      ST_SYNTH: begin
        if (synth_done_i) begin
          load_mid = 1'b1;
          state_d  = ST_HOLD;
        end else begin
          load_smp = 1'b1;
        end
      end
      ST_HOLD: begin
        if (req) begin
          start_d = 1'b1;
          state_d = ST_SYNTH;
        end else if (tmr_done) begin
          state_d = ST_RAMP_DN;
        end
      end
      ST_RAMP_DN: if (tmr_done) begin
        step_dn = 1'b1;
        if (dac_o == DAC_W'(1)) state_d = ST_STANDBY;
      end
      default: state_d = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STANDBY;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  sbr_dac_ramp #(.DAC_W(DAC_W)) i_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_up_i  (step_up),
    .step_dn_i  (step_dn),
    .load_mid_i (load_mid),
    .load_smp_i (load_smp),
    .smp_i      (sample_i),
    .code_o     (dac_o)
  );

  assign standby_o     = (state_q == ST_STANDBY);
  assign busy_no       = !(state_q inside {ST_RAMP_UP, ST_SETTLE, ST_SYNTH});
  assign synth_start_o = start_q;

  assert_standby_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> dac_o == '0);
  assert_wake_needs_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(standby_o) |-> $past(!cs_ni));
  assert_ramp_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAMP_UP && $past(state_q == ST_RAMP_UP))
      |-> (dac_o - $past(dac_o)) <= DAC_W'(1));
  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synth_start_o |=> !synth_start_o);
  assert_start_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synth_start_o |-> !busy_no);
  assert_hold_mid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> dac_o == MID);
endmodule

// File: tb/test_standby_ramp_ctrl.sv
module test_standby_ramp_ctrl;
  localparam int BD  = 3;
  localparam int ST  = 2;
  localparam int SE  = 10;
  localparam int HO  = 40;
  localparam int MID = 256;

  typedef struct packed {
    logic [8:0] smp;
    logic [8:0] exp;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{9'h000, 9'h000}, '{9'h1FF, 9'h1FF}, '{9'h0FF, 9'h0FF},
    '{9'h101, 9'h101}, '{9'h055, 9'h055}, '{9'h1AA, 9'h1AA}};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, tick = 1'b1, cs_n = 1'b1, start_n = 1'b1, wr_n = 1'b1;
  logic       slave = 1'b0, done = 1'b0;
  logic [8:0] sample = 9'h100;
  logic [8:0] dac;
  logic       busy_n, standby, sstart;
  int         errs = 0, chks = 0;

  standby_ramp_ctrl #(
    .BUSY_TICKS(BD), .STEP_TICKS(ST), .SETTLE_TICKS(SE), .HOLD_TICKS(HO)
  ) i_standby_ramp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cs_ni(cs_n), .start_ni(start_n),
    .wr_ni(wr_n), .slave_mode_i(slave), .synth_done_i(done), .sample_i(sample),
    .dac_o(dac), .busy_no(busy_n), .standby_o(standby), .synth_start_o(sstart)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3000000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    int  k;
    int  prev;
    bit  mono;
    nclk(3);
    chk(standby == 1 && dac == 0, "R1 reset standby/dac", dac, 0);
    chk(busy_n == 1 && sstart == 0, "R1 reset busy/start", busy_n, 1);
    rst_n = 1'b1;
    nclk(1);
    chk(standby == 1 && dac == 0 && sstart == 0, "R1 after release", standby, 1);

    // strobes with cs high
    start_n = 1'b0; wr_n = 1'b0;
    nclk(5);
    chk(standby == 1 && dac == 0, "R2 cs high ignored", standby, 1);
    // stand-alone mode: write strobe alone must not wake
    start_n = 1'b1; cs_n = 1'b0;
    nclk(5);
    chk(standby == 1, "R3 wr ignored in stand-alone", standby, 1);
    wr_n = 1'b1; cs_n = 1'b1;
    nclk(2);

    // wake in stand-alone mode
    cs_n = 1'b0; start_n = 1'b0;
    nclk(BD);
    chk(busy_n == 1, "R4 busy still high", busy_n, 1);
    nclk(1);
    chk(busy_n == 0, "R4 busy fall", busy_n, 0);
    cs_n = 1'b1; start_n = 1'b1;
    k = BD + 1;
    nclk(BD + 100 * ST - k);
    chk(dac == 99, "R5 step before", dac, 99);
    nclk(1);
    chk(dac == 100, "R5 step position", dac, 100);
    k = 1 + BD + 100 * ST;
    prev = dac;
    mono = 1'b1;
    while (k < 5000) begin
      nclk(1);
      k++;
      if (dac < prev || dac - prev > 1) mono = 1'b0;
      prev = dac;
      if (sstart) break;
    end
    chk(mono, "R5 monotonic unit steps", mono, 1);
    chk(k == 1 + BD + 256 * ST + SE, "R6 start delay", k, 1 + BD + 256 * ST + SE);
    chk(dac == MID, "R5 reached mid", dac, MID);
    nclk(1);
    chk(sstart == 0, "R6 single pulse", sstart, 0);

    // synthesis: dac follows sample
    for (int i = 0; i < 6; i++) begin
      sample = VEC[i].smp;
      nclk(1);
      chk(dac == VEC[i].exp && busy_n == 0, "R7 sample follow", dac, VEC[i].exp);
    end

    done = 1'b1;
    nclk(1);
    done = 1'b0;
    chk(dac == MID, "R8 hold at mid", dac, MID);
    chk(busy_n == 1 && standby == 0, "R8 busy high in hold", busy_n, 1);

    // restart from hold
    nclk(5);
    cs_n = 1'b0; start_n = 1'b0;
    nclk(1);
    chk(sstart == 1, "R9 immediate start", sstart, 1);
    chk(dac == MID && busy_n == 0, "R9 no ramp", dac, MID);
    cs_n = 1'b1; start_n = 1'b1;
    sample = 9'h0AA;
    nclk(2);
    chk(dac == 9'h0AA, "R7 sample after restart", dac, 9'h0AA);

    // tick gating during hold
    done = 1'b1; tick = 1'b0;
    nclk(1);
    done = 1'b0;
    nclk(100);
    chk(standby == 0 && dac == MID, "R11 frozen without tick", dac, MID);
    tick = 1'b1;
    nclk(HO);
    chk(dac == MID, "R10 ramp-down entry", dac, MID);
    nclk(56 * ST);
    chk(dac == 200, "R10 ramp-down step", dac, 200);
    nclk(200 * ST - 1);
    chk(dac == 1 && standby == 0, "R10 last step", dac, 1);
    nclk(1);
    chk(dac == 0 && standby == 1, "R10 back in standby", dac, 0);

    // slave mode: start ignored, write wakes
    slave = 1'b1; cs_n = 1'b0; start_n = 1'b0;
    nclk(5);
    chk(standby == 1, "R3 start ignored in slave", standby, 1);
    wr_n = 1'b0;
    nclk(1);
    chk(standby == 0, "R3 write wakes slave", standby, 0);
    cs_n = 1'b1; wr_n = 1'b1; start_n = 1'b1;
    nclk(BD);
    chk(busy_n == 0, "R4 slave busy fall", busy_n, 0);

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule